// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry

This block is a purely combinational shifter for the operand path of a 32-bit RISC datapath. In one pass it forms a shifted or rotated copy of a data word and the carry flag that the shift produces. A 3-bit operation select chooses the function. An 8-bit amount gives the distance, and the current carry flag is an input. The result and the carry-out go straight to the ALU and to the flag logic, which sit outside this block.

Every amount from 0 to 255 has a defined result. No case depends on how a native shift operator treats large distances. An amount of zero leaves both the word and the carry untouched. An amount equal to the word width, and any amount beyond it, is handled as an explicit case. The rotate-through-carry operation moves the carry flag into bit 31 and ignores the amount.

Top module: `opnd_shifter`

## Requirements
- R1: Select value 0 is logical left. For amounts 1 to 32 the result is the input shifted left with zeros entering at bit 0. The carry-out is input bit (32 − amount), so an amount of 32 gives result 0 and carry equal to input bit 0.
- R2: Select value 1 is logical right. For amounts 1 to 32 the result is the input shifted right with zeros entering at bit 31. The carry-out is input bit (amount − 1), so an amount of 32 gives result 0 and carry equal to input bit 31.
- R3: For select 0 and select 1, any amount from 33 to 255 gives result 0 and carry-out 0.
- R4: For selects 0 to 3, an amount of 0 returns the input word unchanged, and the carry-out equals the incoming carry.
- R5: Select value 2 is arithmetic right. For amounts 1 to 32, input bit 31 fills the vacated positions, and the carry-out is input bit (amount − 1).
- R6: For select 2 with amounts 33 to 255, a word with bit 31 set gives all ones and carry 1. Any other word gives all zeros and carry 0.
- R7: Select value 3 is rotate right by the amount modulo 32. For nonzero amounts the carry-out equals bit 31 of the result. A nonzero multiple of 32 returns the input unchanged, with carry equal to input bit 31.
- R8: Select value 4 is rotate right through carry by one position. The result is {carry_in, input[31:1]}, the carry-out is input bit 0, and the amount has no effect.
- R9: Select values 5, 6 and 7 return the input word unchanged, with carry-out equal to the incoming carry, whatever the amount.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation select: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 rotate through carry |
| data_in | input | 32 | Word to be shifted |
| amount | input | 8 | Shift distance, 0 to 255 |
| carry_in | input | 1 | Current carry flag |
| data_out | output | 32 | Shifted or rotated word |
| carry_out | output | 1 | Carry produced by the operation |

## Verification
The directed cases cover the amounts 0, 1, 31, 32, 33, 64 and 255 for every select value. These amounts separate the pass-through case, the ordinary shift, the exact-width case where only the carry holds data, and the overflow case. Words with and without bit 31 set separate arithmetic right from logical right. Carry-in values of 0 and 1 show whether the carry flag is passed through or ignored. Random words and amounts cover the ordinary shift distances and the carry bit each one selects. These amounts are spread over the whole 0 to 255 range, so rotate amounts that wrap modulo 32 are hit often.

// File: rtl/opnd_shifter_pkg.sv
package opnd_shifter_pkg;

  typedef enum logic [2:0] {
    SHF_LSL = 3'd0,
    SHF_LSR = 3'd1,
    SHF_ASR = 3'd2,
    SHF_ROR = 3'd3,
    SHF_RRC = 3'd4
  } shf_op_e;

  // Amount that exceeds the data width (full amount compared, never truncated)
  function automatic logic amt_exceeds(input logic [7:0] amt, input int width);
    return int'(amt) > width;
  endfunction

  // Amount within 1..width
  function automatic logic amt_in_range(input logic [7:0] amt, input int width);
    return (amt != 8'd0) && (int'(amt) <= width);
  endfunction

endpackage

// File: rtl/shf_left_unit.sv
module shf_left_unit #(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input  logic [WIDTH-1:0] value,
  input  logic [AMT_W-1:0] amt,
  output logic [WIDTH-1:0] res,
  output logic             cout
);
  import opnd_shifter_pkg::*;
  localparam int SH_W = $clog2(WIDTH);

  // Extended word: bit WIDTH catches the last bit shifted out
  logic [WIDTH:0] stg [SH_W+2];
  logic           over;

  assign stg[0] = {1'b0, value};

  for (genvar s = 0; s <= SH_W; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stg[s+1] = amt[s] ? {stg[s][WIDTH-D:0], {D{1'b0}}} : stg[s];
  end

  assign over = amt_exceeds(8'(amt), WIDTH);
  assign res  = over ? '0   : stg[SH_W+1][WIDTH-1:0];
  assign cout = over ? 1'b0 : stg[SH_W+1][WIDTH];

  always_comb begin
    if (amt_in_range(8'(amt), WIDTH))
      AST_LSL_CARRY: assert (cout == value[WIDTH - int'(amt)]); // R1
    if (over)
      AST_LSL_OVER: assert (res == '0 && !cout); // R3
  end

endmodule

// File: rtl/shf_right_unit.sv
module shf_right_unit #(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8,
  parameter bit ARITH = 1'b0
) (
  input  logic [WIDTH-1:0] value,
  input  logic [AMT_W-1:0] amt,
  output logic [WIDTH-1:0] res,
  output logic             cout
);
  import opnd_shifter_pkg::*;
  localparam int SH_W = $clog2(WIDTH);

  logic           fill;
  logic           over;
  // Extended word: bit 0 catches the last bit shifted out
  logic [WIDTH:0] stg [SH_W+2];

  if (ARITH) begin : g_arith
    assign fill = value[WIDTH-1];
  end else begin : g_logic
    assign fill = 1'b0;
  end

  assign stg[0] = {value, 1'b0};

  for (genvar s = 0; s <= SH_W; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stg[s+1] = amt[s] ? {{D{fill}}, stg[s][WIDTH:D]} : stg[s];
  end

  assign over = amt_exceeds(8'(amt), WIDTH);
  assign res  = over ? {WIDTH{fill}} : stg[SH_W+1][WIDTH:1];
  assign cout = over ? fill          : stg[SH_W+1][0];

  always_comb begin
    if (amt_in_range(8'(amt), WIDTH))
      AST_RIGHT_CARRY: assert (cout == value[int'(amt) - 1]); // R2
    if (ARITH && amt_in_range(8'(amt), WIDTH))
      AST_ASR_SIGN: assert (res[WIDTH-1] == value[WIDTH-1]); // R5
    if (ARITH && over)
      AST_ASR_OVER: assert ($countones(res) == (value[WIDTH-1] ? WIDTH : 0)); // R6
  end

endmodule

// File: rtl/shf_rotate_unit.sv
module shf_rotate_unit #(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input  logic [WIDTH-1:0] value,
  input  logic [AMT_W-1:0] amt,
  output logic [WIDTH-1:0] res
);
  localparam int SH_W = $clog2(WIDTH);

  // Only the low SH_W bits matter: rotation is modulo WIDTH
  logic [WIDTH-1:0] stg [SH_W+1];

  assign stg[0] = value;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stg[s+1] = amt[s] ? {stg[s][D-1:0], stg[s][WIDTH-1:D]} : stg[s];
  end

  assign res = stg[SH_W];

  always_comb begin
    AST_ROR_ONES: assert ($countones(res) == $countones(value)); // R7
    if (amt[SH_W-1:0] == '0)
      AST_ROR_WRAP: assert (res == value); // R7
  end

endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter #(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input  logic [2:0]       op_sel,
  input  logic [WIDTH-1:0] data_in,
  input  logic [AMT_W-1:0] amount,
  input  logic             carry_in,
  output logic [WIDTH-1:0] data_out,
  output logic             carry_out
);
  import opnd_shifter_pkg::*;

  logic [WIDTH-1:0] lsl_res, lsr_res, asr_res, ror_res;
  logic             lsl_c, lsr_c, asr_c;
  logic             amt_zero;

  assign amt_zero = (amount == '0);

  shf_left_unit #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_lsl (
    .value(data_in), .amt(amount), .res(lsl_res), .cout(lsl_c)
  );

  shf_right_unit #(.WIDTH(WIDTH), .AMT_W(AMT_W), .ARITH(1'b0)) u_lsr (
    .value(data_in), .amt(amount), .res(lsr_res), .cout(lsr_c)
  );

  shf_right_unit #(.WIDTH(WIDTH), .AMT_W(AMT_W), .ARITH(1'b1)) u_asr (
    .value(data_in), .amt(amount), .res(asr_res), .cout(asr_c)
  );

  shf_rotate_unit #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_ror (
    .value(data_in), .amt(amount), .res(ror_res)
  );

  always_comb begin
    data_out  = data_in;
    carry_out = carry_in;
    case (shf_op_e'(op_sel))
      SHF_LSL: if (!amt_zero) begin data_out = lsl_res; carry_out = lsl_c; end
      SHF_LSR: if (!amt_zero) begin data_out = lsr_res; carry_out = lsr_c; end
      SHF_ASR: if (!amt_zero) begin data_out = asr_res; carry_out = asr_c; end
      SHF_ROR: if (!amt_zero) begin data_out = ror_res; carry_out = ror_res[WIDTH-1]; end
      SHF_RRC: begin
        data_out  = {carry_in, data_in[WIDTH-1:1]};
        carry_out = data_in[0];
      end
      default: ;
    endcase
  end

  always_comb begin
    if (amt_zero && op_sel <= 3'd3)
      AST_ZERO_PASS: assert (data_out == data_in && carry_out == carry_in); // R4
    if (op_sel == 3'd4)
      AST_RRC_ONES: assert (($countones(data_out) + 32'(carry_out)) ==
                            ($countones(data_in) + 32'(carry_in))); // R8
    if (op_sel > 3'd4)
      AST_SPARE_PASS: assert (data_out == data_in && carry_out == carry_in); // R9
  end

endmodule

// File: tb/sim_opnd_shifter.sv
`timescale 1ns/1ps
module sim_opnd_shifter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [31:0] data_in = '0;
  logic [7:0]  amount = '0;
  logic        carry_in = 1'b0;
  logic [31:0] data_out;
  logic        carry_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  opnd_shifter u0 (
    .op_sel(op_sel), .data_in(data_in), .amount(amount),
    .carry_in(carry_in), .data_out(data_out), .carry_out(carry_out)
  );

  // Reference model: bit-by-bit, {carry, result}
  function automatic logic [32:0] model(input logic [2:0] op, input logic [31:0] v,
                                        input int n, input logic ci);
    logic [31:0] r;
    logic        c;
    r = v;
    c = ci;
    case (op)
      3'd0: if (n != 0) begin
        for (int i = 0; i < 32; i++) r[i] = (i - n >= 0) ? v[i-n] : 1'b0;
        c = (n <= 32) ? v[32-n] : 1'b0;
      end
      3'd1: if (n != 0) begin
        for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? v[i+n] : 1'b0;
        c = (n <= 32) ? v[n-1] : 1'b0;
      end
      3'd2: if (n != 0) begin
        for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? v[i+n] : v[31];
        c = (n <= 32) ? v[n-1] : v[31];
      end
      3'd3: if (n != 0) begin
        for (int i = 0; i < 32; i++) r[i] = v[(i + n) % 32];
        c = r[31];
      end
      3'd4: begin
        r = {ci, v[31:1]};
        c = v[0];
      end
      default: ;
    endcase
    return {c, r};
  endfunction

  task automatic apply(input logic [2:0] op, input logic [31:0] v, input int n,
                       input logic ci, input string req);
    logic [32:0] exp;
    @(posedge clk);
    #1;
    op_sel = op; data_in = v; amount = 8'(n); carry_in = ci;
    exp = model(op, v, n, ci);
    @(negedge clk);
    checks++;
    if ({carry_out, data_out} !== exp) begin
      errors++;
      $display("FAIL %s op=%0d v=%h n=%0d ci=%0b actual c=%0b r=%h expected c=%0b r=%h",
               req, op, v, n, ci, carry_out, data_out, exp[32], exp[31:0]);
    end
  endtask

  function automatic string req_of(input logic [2:0] op, input int n);
    case (op)
      3'd0: return (n == 0) ? "R4" : (n > 32) ? "R3" : "R1";
      3'd1: return (n == 0) ? "R4" : (n > 32) ? "R3" : "R2";
      3'd2: return (n == 0) ? "R4" : (n > 32) ? "R6" : "R5";
      3'd3: return (n == 0) ? "R4" : "R7";
      3'd4: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    int amts [7] = '{0, 1, 31, 32, 33, 64, 255};
    logic [31:0] words [4] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_0F96, 32'h0000_0000};
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: all-zero inputs give all-zero outputs (R4)
    apply(3'd0, 32'h0, 0, 1'b0, "R4");

    // Directed corners over every select, amount and carry
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 7; a++)
        for (int w = 0; w < 4; w++)
          for (int ci = 0; ci < 2; ci++)
            apply(3'(op), words[w], amts[a], 1'(ci), req_of(3'(op), amts[a]));

    // R7: nonzero multiples of 32 leave the word, carry is bit 31
    apply(3'd3, 32'h8000_0000, 96, 1'b0, "R7");
    apply(3'd3, 32'h1234_5678, 128, 1'b1, "R7");
    // R8: amount has no effect on rotate through carry
    apply(3'd4, 32'h0000_0003, 200, 1'b1, "R8");
    // R3: large amounts are not taken modulo
    apply(3'd0, 32'hFFFF_FFFF, 65, 1'b1, "R3");
    apply(3'd1, 32'hFFFF_FFFF, 160, 1'b1, "R3");

    // Random stimulus
    for (int k = 0; k < 4000; k++) begin
      logic [2:0] op;
      int n;
      op = 3'($urandom_range(0, 7));
      n  = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 255))
                                       : int'($urandom_range(0, 33));
      apply(op, $urandom, n, 1'($urandom), req_of(op, n));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule